// File: doc/BRIEF.md
# Framed Serial DAC Input Receiver

This block is the digital front end of a serial-input DAC. A host writes 16-bit words over a three-wire, write-only link: an active-low frame select, a serial clock and a data line. All three lines are brought into a faster system clock through two-flop synchronizers, and their edges are detected there. The serial clock must run at no more than one quarter of the system clock rate.

A frame opens when the select line falls. The bit counter and the shift register are then cleared. Data is sampled on each falling edge of the serial clock, most significant bit first. On the 16th falling edge the word moves into the DAC holding register, and an update strobe pulses for one system clock. If the select line rises before the 16th edge, the partial word is dropped, the holding register keeps its old value, and an abort flag pulses instead. Serial clock edges after the 16th, while select stays low, have no effect until the select line goes high and then low again. The raw 16-bit word, mode bits included, is presented unchanged on the holding register output.

Top module: `sdac_frame_rx`

## Requirements
- R1: After reset, hold_o is 16'h0000, and update_o and abort_o are low.
- R2: Bits shift in most significant first. The first bit sampled in a frame ends up in hold_o[15], and the 16th ends up in hold_o[0].
- R3: Data is sampled only on falling edges of sclk_i while sync_ni is low. Rising edges of sclk_i, changes on din_i while sclk_i is low, and sclk_i activity while sync_ni is high change nothing.
- R4: The 16th falling sclk_i edge of a frame loads hold_o with the frame. update_o is high for exactly one system clock in that cycle, three system clock edges after the edge is present at the pins.
- R5: A rise of sync_ni after 0 to 15 falling edges of a frame leaves hold_o unchanged and raises no update_o. It pulses abort_o for one cycle, and abort_o and update_o are never high together.
- R6: Falling sclk_i edges after the 16th, within the same low period of sync_ni, cause no second update and do not change hold_o.
- R7: Every falling edge of sync_ni restarts the bit count and clears the shift register, so a frame sent after an aborted one is received correctly.
- R8: A rise of sync_ni after a completed frame raises no abort_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, asynchronous to clk_i |
| sync_ni | input | 1 | Active-low frame select |
| din_i | input | 1 | Serial data, sampled on falling sclk_i |
| hold_o | output | 16 | DAC holding register, raw frame |
| update_o | output | 1 | One-cycle pulse when a frame is committed |
| abort_o | output | 1 | One-cycle pulse when a frame is cancelled |

## Verification
The bench targets frames cut off after 0, 10 and 15 bits. A design that commits too early, or that counts off by one, would load a garbage word or raise update_o instead of abort_o. It sends frames with extra clock edges past the 16th, where a counter that wraps would commit a second, shifted word. It flips din_i while sclk_i is low and toggles sclk_i with select high, which catches sampling on the wrong edge and a shifter that is not gated by select. Words with a single bit set at either end catch a reversed bit order, and a frame sent right after an abort catches a counter that is not cleared at frame start.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int unsigned LINE_W   = 3;
  localparam int unsigned IDX_SCLK = 0;
  localparam int unsigned IDX_SYNC = 1;
  localparam int unsigned IDX_DIN  = 2;
  // idle bus: sclk high, select high, data low
  localparam logic [LINE_W-1:0] LINE_IDLE = 3'b011;

  typedef struct packed {
    logic sclk_fall;
    logic sync_fall;
    logic sync_rise;
    logic sync_low;
    logic din;
  } line_ev_t;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sdac_edge.sv
module sdac_edge
  import sdac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] line_i,
  output line_ev_t          ev_o
);
  logic [LINE_W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= LINE_IDLE;
    else         prev_q <= line_i;
  end

  always_comb begin
    ev_o.sclk_fall = prev_q[IDX_SCLK] & ~line_i[IDX_SCLK];
    ev_o.sync_fall = prev_q[IDX_SYNC] & ~line_i[IDX_SYNC];
    ev_o.sync_rise = ~prev_q[IDX_SYNC] & line_i[IDX_SYNC];
    ev_o.sync_low  = ~line_i[IDX_SYNC];
    ev_o.din       = line_i[IDX_DIN];
  end
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
  import sdac_pkg::*;
#(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  line_ev_t           ev_i,
  output logic [FRAME_W-1:0] word_o,
  output logic               done_o,
  output logic               abort_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic               active_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sh_q;
  logic               done_q, abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      done_q   <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      if (ev_i.sync_fall) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        sh_q     <= '0;
      end else if (ev_i.sync_rise) begin
        if (active_q) abort_q <= 1'b1;
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else if (ev_i.sclk_fall && active_q && ev_i.sync_low) begin
        sh_q <= {sh_q[FRAME_W-2:0], ev_i.din};
        if (cnt_q == LAST) begin
          done_q   <= 1'b1;
          active_q <= 1'b0;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign word_o  = sh_q;
  assign done_o  = done_q;
  assign abort_o = abort_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R4
  AST_ABORT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q |-> $past(ev_i.sync_rise)); // R5
  AST_IDLE_NO_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !ev_i.sync_fall) |=> $stable(sh_q)); // R6
endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx
  import sdac_pkg::*;
#(
  parameter int unsigned FRAME_W     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               sync_ni,
  input  logic               din_i,
  output logic [FRAME_W-1:0] hold_o,
  output logic               update_o,
  output logic               abort_o
);
  logic [LINE_W-1:0]  line_raw, line_s;
  line_ev_t           ev;
  logic [FRAME_W-1:0] word;
  logic               done, cancel;
  logic [FRAME_W-1:0] hold_q;
  logic               update_q, abort_q;

  always_comb begin
    line_raw           = '0;
    line_raw[IDX_SCLK] = sclk_i;
    line_raw[IDX_SYNC] = sync_ni;
    line_raw[IDX_DIN]  = din_i;
  end

  sdac_sync #(
    .WIDTH  (LINE_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(LINE_IDLE)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_raw),
    .q_o   (line_s)
  );

  sdac_edge i_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i(line_s),
    .ev_o  (ev)
  );

  sdac_shifter #(.FRAME_W(FRAME_W)) i_shifter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev),
    .word_o (word),
    .done_o (done),
    .abort_o(cancel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= '0;
      update_q <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      update_q <= done;
      abort_q  <= cancel;
      if (done) hold_q <= word;
    end
  end

  assign hold_o   = hold_q;
  assign update_o = update_q;
  assign abort_o  = abort_q;

  AST_UPDATE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o); // R4
  AST_ABORT_KEEPS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $stable(hold_o)); // R5
  AST_UPD_ABORT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(update_o && abort_o)); // R5
endmodule

// File: tb/test_sdac_frame_rx.sv
module test_sdac_frame_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1, sync_n = 1'b1, din = 1'b0;
  logic [15:0] hold;
  logic        upd, abt;
  int          checks = 0, errors = 0;
  int          upd_cnt = 0, abt_cnt = 0;
  bit          done = 0;

  always #10 clk = ~clk; // 50 MHz

  sdac_frame_rx i_sdac_frame_rx (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sync_ni(sync_n),
    .din_i(din), .hold_o(hold), .update_o(upd), .abort_o(abt)
  );

  // behavioural reference: {hold, update, abort}, three-edge latency
  logic [17:0] pipe [$];
  logic [17:0] exp_now;
  logic        m_sclk, m_sync, m_open;
  int          m_bits;
  logic [15:0] m_sh, m_hold;

  always @(posedge clk) begin
    logic u, a;
    if (!rst_n) begin
      pipe = '{18'd0, 18'd0, 18'd0};
      exp_now = '0;
      m_sclk = 1'b1; m_sync = 1'b1; m_open = 1'b0;
      m_bits = 0; m_sh = '0; m_hold = '0;
    end else begin
      u = 1'b0; a = 1'b0;
      if (m_sync && !sync_n) begin
        m_open = 1'b1; m_bits = 0; m_sh = '0;
      end else if (!m_sync && sync_n) begin
        a = m_open; m_open = 1'b0;
      end else if (m_sclk && !sclk && m_open) begin
        m_sh = {m_sh[14:0], din};
        m_bits++;
        if (m_bits == 16) begin
          m_hold = m_sh; u = 1'b1; m_open = 1'b0;
        end
      end
      m_sclk = sclk; m_sync = sync_n;
      pipe.push_back({m_hold, u, a});
      exp_now = pipe.pop_front();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (upd) upd_cnt++;
      if (abt) abt_cnt++;
      chk("R2 R4 hold vs model", 32'(hold), 32'(exp_now[17:2]));
      chk("R4 update vs model", 32'(upd), 32'(exp_now[1]));
      chk("R5 abort vs model", 32'(abt), 32'(exp_now[0]));
    end
  end

  task automatic bit_clk(input logic b, input logic flip);
    din = b;
    repeat (2) @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
    if (flip) din = ~b;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] w, input int nbits, input int extra, input logic flip);
    sync_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) bit_clk(w[15-i], flip);
    for (int i = 0; i < extra; i++) bit_clk(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    sync_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic expect_frame(input string tag, input logic [15:0] h, input int du, input int da,
                              input int u0, input int a0);
    chk({tag, " hold"}, 32'(hold), 32'(h));
    chk({tag, " updates"}, 32'(upd_cnt - u0), 32'(du));
    chk({tag, " aborts"}, 32'(abt_cnt - a0), 32'(da));
  endtask

  initial begin
    int u0, a0;
    logic [15:0] w;
    repeat (3) @(negedge clk);
    chk("R1 hold reset", 32'(hold), 32'h0);
    chk("R1 update reset", 32'(upd), 32'h0);
    chk("R1 abort reset", 32'(abt), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    u0 = upd_cnt; a0 = abt_cnt;
    frame(16'hA5C3, 16, 0, 1'b0);
    expect_frame("R4 R8 full frame", 16'hA5C3, 1, 0, u0, a0);

    u0 = upd_cnt; a0 = abt_cnt;
    frame(16'h8000, 16, 0, 1'b0);
    expect_frame("R2 msb end", 16'h8000, 1, 0, u0, a0);
    u0 = upd_cnt; a0 = abt_cnt;
    frame(16'h0001, 16, 0, 1'b0);
    expect_frame("R2 lsb end", 16'h0001, 1, 0, u0, a0);

    u0 = upd_cnt; a0 = abt_cnt;
    frame(16'h1234, 10, 0, 1'b0);
    expect_frame("R5 abort at 10", 16'h0001, 0, 1, u0, a0);
    u0 = upd_cnt; a0 = abt_cnt;
    frame(16'hFFFF, 15, 0, 1'b0);
    expect_frame("R5 abort at 15", 16'h0001, 0, 1, u0, a0);
    u0 = upd_cnt; a0 = abt_cnt;
    frame(16'hFFFF, 0, 0, 1'b0);
    expect_frame("R5 abort at 0", 16'h0001, 0, 1, u0, a0);

    u0 = upd_cnt; a0 = abt_cnt;
    frame(16'h5A5A, 16, 0, 1'b0);
    expect_frame("R7 after abort", 16'h5A5A, 1, 0, u0, a0);

    u0 = upd_cnt; a0 = abt_cnt;
    frame(16'h0F0F, 16, 5, 1'b0);
    expect_frame("R6 extra edges", 16'h0F0F, 1, 0, u0, a0);

    u0 = upd_cnt; a0 = abt_cnt;
    for (int i = 0; i < 20; i++) bit_clk(i[0], 1'b0);
    repeat (8) @(negedge clk);
    expect_frame("R3 sync high", 16'h0F0F, 0, 0, u0, a0);

    u0 = upd_cnt; a0 = abt_cnt;
    frame(16'hC3A6, 16, 0, 1'b1);
    expect_frame("R3 falling edge only", 16'hC3A6, 1, 0, u0, a0);

    for (int i = 0; i < 20; i++) begin
      w = 16'($urandom);
      u0 = upd_cnt; a0 = abt_cnt;
      frame(w, 16, i % 3, i[1]);
      expect_frame("R2 R4 random", w, 1, 0, u0, a0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule